// File: doc/BRIEF.md
# Block-Parallel Base64 Encoder with Writable Alphabet

This block converts raw binary into base64 text one wide block at a time. Each accepted transfer carries 48 bytes, which form 16 three-byte groups. Each group is split into four 6-bit indices, and every index selects a character from a 64-entry alphabet table. A single output transfer returns the resulting 64 characters.

The bit regrouping does not use per-field masks and shifts. Each group is first copied into a 32-bit lane as the byte pattern (s2, s1, s3, s2), from low byte to high byte. Neighbouring lanes are then joined into 64-bit words. Each output index is the low six bits of one fixed right rotation of such a word.

The alphabet table loads with the standard character set at reset. Software can rewrite any entry through a separate write port, so the URL-safe set or any other 64-byte mapping only needs a table reload. The block handles complete 48-byte blocks only. A short final group, its '=' padding and line breaks belong to a separate tail path.

Top module: `b64_block_enc`

## Requirements
- R1: While reset is held and in the first cycle after it, `outValid` is 0 and `inReady` is 1.
- R2: Input byte i of a block is `inData[8*i+7:8*i]`. Group g consists of bytes 3g, 3g+1 and 3g+2, called s1, s2 and s3.
- R3: Group g yields output characters 4g to 4g+3. Their indices, in order, are s1>>2, ((s1&3)<<4)|(s2>>4), ((s2&15)<<2)|(s3>>6) and s3&63. Output character j is `outData[8*j+7:8*j]`.
- R4: After reset, table entry i holds 'A'+i for i<26, 'a'+i-26 for 26≤i<52, '0'+i-52 for 52≤i<62, '+' (0x2B) at 62 and '/' (0x2F) at 63.
- R5: A table write (`tblWrEn`=1) stores `tblWrData` at entry `tblWrAddr`. It affects every block accepted in a later cycle. A block accepted in the same cycle as the write still uses the old entry.
- R6: A table write made while a block is waiting at the output does not change that block's characters.
- R7: While `outValid` is 1 and `outReady` is 0, `outValid` and `outData` hold their values.
- R8: `inReady` is 1 exactly when the output is empty or is being consumed in the same cycle. A block is accepted when `inValid` and `inReady` are both 1, so back-to-back blocks can be accepted on every cycle.
- R9: An accepted block appears at the output with `outValid`=1 in the next cycle. The output empties one cycle after it is consumed if no new block is accepted in that cycle.
- R10: Any 64-byte content of the table is honoured, including byte values outside the ASCII range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input block is present |
| inReady | output | 1 | Block can accept input this cycle |
| inData | input | 384 | 48 raw bytes, byte 0 in the low bits |
| outValid | output | 1 | Output characters are present |
| outReady | input | 1 | Consumer takes the output this cycle |
| outData | output | 512 | 64 characters, character 0 in the low bits |
| tblWrEn | input | 1 | Alphabet table write strobe |
| tblWrAddr | input | 6 | Table entry to write |
| tblWrData | input | 8 | Character value to store |

## Verification
Every index value 0 to 63 is driven through one block. A wrong rotation amount or a swapped lane byte then shows up as a misplaced or corrupted character, not as a silent match. All-zero and all-ones blocks and seeded random blocks are compared against a bit-serial reference model under both the standard and URL-safe tables.

The timing of table writes is attacked in two places. A write lands while a block is stalled at the output, and a design that looked up characters at the output would change the pending characters. A write lands in the same cycle as an accept, and a design that forwarded the write would encode that block with the new entry.

Backpressure is checked as well. A design that accepted input into a full output register would lose a block, and one that missed the same-cycle drain-and-refill would drop throughput.

// File: rtl/b64_enc_pkg.sv
`timescale 1ns/1ps
package b64_enc_pkg;

  localparam int unsigned ALPHA_N  = 64;
  localparam int unsigned ALPHA_AW = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a freshly encoded block
    logic drop;   // output consumed with nothing behind it
  } encStrb_t;

  // standard character for a 6-bit index
  function automatic logic [7:0] stdChar(input int unsigned idx);
    logic [7:0] c;
    if (idx < 26)      c = 8'(8'h41 + idx);
    else if (idx < 52) c = 8'(8'h61 + (idx - 26));
    else if (idx < 62) c = 8'(8'h30 + (idx - 52));
    else if (idx == 62) c = 8'h2B;
    else               c = 8'h2F;
    return c;
  endfunction

  // rotation used for output byte k of a 64-bit lane pair
  function automatic int unsigned rotFor(input int unsigned k);
    int unsigned base;
    case (k % 4)
      0: base = 10;
      1: base = 4;
      2: base = 22;
      default: base = 16;
    endcase
    return (k >= 4) ? base + 32 : base;
  endfunction

endpackage

// File: rtl/b64_enc_ctrl.sv
`timescale 1ns/1ps
module b64_enc_ctrl
  import b64_enc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     inValid,
  input  logic     outReady,
  output logic     inReady,
  output logic     outValid,
  output encStrb_t strb
);

  logic fullQ;
  logic accept;

  assign inReady  = !fullQ || outReady;
  assign accept   = inValid && inReady;
  assign outValid = fullQ;

  always_comb begin
    strb      = '0;
    strb.load = accept;
    strb.drop = fullQ && outReady && !accept;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         fullQ <= 1'b0;
    else if (strb.load) fullQ <= 1'b1;
    else if (strb.drop) fullQ <= 1'b0;
  end

  // R9: an accepted block is presented on the following cycle
  p_load_shows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> outValid);

  // R9: a consumed block with no successor empties the output
  p_drain_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady && !inValid) |=> !outValid);

  // R7: a stalled output stays valid
  p_stall_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid);

endmodule

// File: rtl/b64_enc_dp.sv
`timescale 1ns/1ps
module b64_enc_dp
  import b64_enc_pkg::*;
#(
  parameter int unsigned PAIRS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  encStrb_t                  strb,
  input  logic [PAIRS*48-1:0]       inData,
  input  logic                      tblWrEn,
  input  logic [ALPHA_AW-1:0]       tblWrAddr,
  input  logic [7:0]                tblWrData,
  output logic [PAIRS*64-1:0]       outData
);

  localparam int unsigned GROUPS = 2 * PAIRS;
  localparam int unsigned CHARS  = 4 * GROUPS;

  logic [7:0]  alpha [ALPHA_N];
  logic [31:0] lane  [GROUPS];
  logic [CHARS*8-1:0] encoded;
  logic [CHARS*8-1:0] outQ;

  // alphabet table, reset to the standard set
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ALPHA_N; i++) alpha[i] <= stdChar(i);
    end else if (tblWrEn) begin
      alpha[tblWrAddr] <= tblWrData;
    end
  end

  // spread each group to (s2, s1, s3, s2), low byte first
  for (genvar g = 0; g < GROUPS; g++) begin : gLane
    logic [7:0] s1, s2, s3;
    assign s1 = inData[24*g +: 8];
    assign s2 = inData[24*g + 8 +: 8];
    assign s3 = inData[24*g + 16 +: 8];
    assign lane[g] = {s2, s3, s1, s2};
  end

  // rotate each lane pair and map the low six bits through the table
  for (genvar p = 0; p < PAIRS; p++) begin : gPair
    logic [63:0] word;
    assign word = {lane[2*p+1], lane[2*p]};
    for (genvar k = 0; k < 8; k++) begin : gByte
      localparam int unsigned ROT = rotFor(k);
      logic [63:0] rotated;
      logic [ALPHA_AW-1:0] idx;
      assign rotated = (word >> ROT) | (word << (64 - ROT));
      assign idx     = rotated[ALPHA_AW-1:0];
      assign encoded[8*(8*p+k) +: 8] = alpha[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         outQ <= '0;
    else if (strb.load) outQ <= encoded;
    else if (strb.drop) outQ <= '0;
  end

  assign outData = outQ;

  // R5: a write lands in the addressed table entry
  p_tbl_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tblWrEn |=> (alpha[$past(tblWrAddr)] == $past(tblWrData)));

endmodule

// File: rtl/b64_block_enc.sv
`timescale 1ns/1ps
module b64_block_enc
  import b64_enc_pkg::*;
#(
  parameter int unsigned PAIRS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [PAIRS*48-1:0]   inData,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [PAIRS*64-1:0]   outData,
  input  logic                  tblWrEn,
  input  logic [ALPHA_AW-1:0]   tblWrAddr,
  input  logic [7:0]            tblWrData
);

  encStrb_t strb;

  b64_enc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  b64_enc_dp #(.PAIRS(PAIRS)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .inData    (inData),
    .tblWrEn   (tblWrEn),
    .tblWrAddr (tblWrAddr),
    .tblWrData (tblWrData),
    .outData   (outData)
  );

  // R7 and R6: characters waiting at the output do not move, table writes included
  p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> $stable(outData));

  // R8: a full, stalled output refuses input
  p_full_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |-> !inReady);

endmodule

// File: tb/b64_block_enc_tb.sv
`timescale 1ns/1ps
module b64_block_enc_tb;

  localparam int NB = 48;
  localparam int NC = 64;

  // {urlSafe, seed}; seed 0 = all zero, seed 1 = all ones, others random
  localparam logic [32:0] VEC [8] = '{
    {1'b0, 32'h0000_0000}, {1'b0, 32'h0000_0001}, {1'b0, 32'h1234_5678},
    {1'b0, 32'hCAFE_0042}, {1'b1, 32'h0000_0001}, {1'b1, 32'h9E37_79B9},
    {1'b1, 32'h0BAD_F00D}, {1'b0, 32'h7777_1111}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [NB*8-1:0] inData = '0;
  logic outValid;
  logic outReady = 1'b0;
  logic [NC*8-1:0] outData;
  logic tblWrEn = 1'b0;
  logic [5:0] tblWrAddr = '0;
  logic [7:0] tblWrData = '0;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;
  logic [7:0] refTbl [64];

  always #4 clk = ~clk;

  b64_block_enc u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inData(inData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr),
    .tblWrData(tblWrData)
  );

  function automatic logic [7:0] stdRef(input int i);
    string s = "ABCDEFGHIJKLMNOPQRSTUVWXYZabcdefghijklmnopqrstuvwxyz0123456789+/";
    return s[i];
  endfunction

  // bit-serial reference: walk the stream MSB first, six bits at a time
  function automatic logic [NC*8-1:0] refEnc(input logic [NB*8-1:0] blk);
    logic [NC*8-1:0] r = '0;
    for (int j = 0; j < NC; j++) begin
      logic [5:0] idx = '0;
      for (int b = 0; b < 6; b++) begin
        int t = 6*j + b;
        idx = {idx[4:0], blk[8*(t/8) + 7 - (t%8)]};
      end
      r[8*j +: 8] = refTbl[idx];
    end
    return r;
  endfunction

  function automatic logic [NB*8-1:0] mkBlock(input logic [31:0] seed);
    logic [NB*8-1:0] b;
    logic [31:0] x = seed;
    for (int i = 0; i < NB; i++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      b[8*i +: 8] = (seed == 0) ? 8'h00 : (seed == 1) ? 8'hFF : x[31:24];
    end
    return b;
  endfunction

  // block whose index stream is 0,1,2,...,63
  function automatic logic [NB*8-1:0] idxBlock();
    logic [NB*8-1:0] b = '0;
    for (int j = 0; j < NC; j++)
      for (int k = 0; k < 6; k++) begin
        int t = 6*j + k;
        b[8*(t/8) + 7 - (t%8)] = 1'(j >> (5 - k));
      end
    return b;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [NC*8-1:0] act,
                       input logic [NC*8-1:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrTbl(input int a, input logic [7:0] d);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrAddr = 6'(a); tblWrData = d;
    @(negedge clk);
    tblWrEn = 1'b0;
    refTbl[a] = d;
  endtask

  // one block through with outReady high; checked at the next negedge
  task automatic encodeOne(input logic [NB*8-1:0] blk, input string tag);
    logic [NC*8-1:0] exp = refEnc(blk);
    @(negedge clk);
    outReady = 1'b1; inValid = 1'b1; inData = blk;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1 && outData === exp, tag, outData, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [NC*8-1:0] expA, expB, expC;
    logic [NB*8-1:0] blkA, blkB;
    for (int i = 0; i < 64; i++) refTbl[i] = stdRef(i);

    // R1: reset state
    repeat (3) @(negedge clk);
    check(outValid === 1'b0 && inReady === 1'b1, "R1 reset state",
          {outValid, inReady}, {1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0 && inReady === 1'b1, "R1 after reset",
          {outValid, inReady}, {1'b0, 1'b1});

    // R4 R3: index stream 0..63 must spell the alphabet in order
    begin
      logic [NC*8-1:0] alpha;
      for (int i = 0; i < 64; i++) alpha[8*i +: 8] = stdRef(i);
      encodeOne(idxBlock(), "R4 default table order");
      check(outData === alpha, "R3 index order", outData, alpha);
    end

    // R2 R3: known triplet "Man" -> "TWFu"
    begin
      logic [NB*8-1:0] man;
      logic [NC*8-1:0] twfu;
      for (int g = 0; g < 16; g++) begin
        man[24*g +: 24] = {8'h6E, 8'h61, 8'h4D};
        twfu[32*g +: 32] = {8'h75, 8'h46, 8'h57, 8'h54};
      end
      encodeOne(man, "R2 byte order Man");
      check(outData === twfu, "R3 TWFu literal", outData, twfu);
    end

    // vector table walk: standard and URL-safe alphabets
    foreach (VEC[v]) begin
      if (VEC[v][32] && refTbl[62] != 8'h2D) begin
        wrTbl(62, 8'h2D); wrTbl(63, 8'h5F);
      end else if (!VEC[v][32] && refTbl[62] != 8'h2B) begin
        wrTbl(62, 8'h2B); wrTbl(63, 8'h2F);
      end
      encodeOne(mkBlock(VEC[v][31:0]), VEC[v][32] ? "R5 url-safe vector" : "R3 standard vector");
    end

    // R8: back-to-back accepts at full rate
    blkA = mkBlock(32'hA1A1_0001); blkB = mkBlock(32'hB2B2_0002);
    expA = refEnc(blkA); expB = refEnc(blkB);
    @(negedge clk);
    outReady = 1'b1; inValid = 1'b1; inData = blkA;
    @(negedge clk);
    check(inReady === 1'b1, "R8 ready while draining", inReady, 1'b1);
    check(outData === expA, "R9 first of pair", outData, expA);
    inData = blkB;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1 && outData === expB, "R8 second of pair", outData, expB);
    @(negedge clk);
    check(outValid === 1'b0, "R9 empties after drain", outValid, 1'b0);

    // R7 R6 R8: stall, table write while stalled, then drain-and-refill
    blkA = mkBlock(32'h5150_AAAA); blkB = idxBlock();
    expA = refEnc(blkA);
    @(negedge clk);
    outReady = 1'b0; inValid = 1'b1; inData = blkA;
    @(negedge clk);
    inData = blkB;
    #1;
    check(inReady === 1'b0, "R8 full output refuses", inReady, 1'b0);
    check(outData === expA, "R9 stalled block", outData, expA);
    tblWrEn = 1'b1; tblWrAddr = 6'd0; tblWrData = 8'h23;
    @(negedge clk);
    tblWrEn = 1'b0; refTbl[0] = 8'h23;
    @(negedge clk);
    check(outValid === 1'b1 && outData === expA, "R6 R7 hold through write", outData, expA);
    outReady = 1'b1;
    #1;
    check(inReady === 1'b1, "R8 drain and refill", inReady, 1'b1);
    expB = refEnc(blkB);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1 && outData === expB, "R5 new entry applies", outData, expB);

    // R5: write in the same cycle as an accept uses the old entry
    expC = refEnc(idxBlock());
    @(negedge clk);
    inValid = 1'b1; inData = idxBlock();
    tblWrEn = 1'b1; tblWrAddr = 6'd1; tblWrData = 8'h40;
    @(negedge clk);
    inValid = 1'b0; tblWrEn = 1'b0; refTbl[1] = 8'h40;
    check(outData === expC, "R5 same-cycle write not forwarded", outData, expC);
    encodeOne(idxBlock(), "R5 write visible next block");

    // R10: arbitrary non-ASCII mapping
    for (int i = 0; i < 64; i++) wrTbl(i, 8'(8'hC0 ^ (i * 3)));
    encodeOne(idxBlock(), "R10 arbitrary table");
    encodeOne(mkBlock(32'h0F0F_3C3C), "R10 arbitrary random");

    @(negedge clk);
    finishRun();
  end

endmodule